// File: doc/BRIEF.md
# Serial Burst Data Engine with CRC-32

This block carries the data phase of a debug burst once a read or write command has been decoded elsewhere. It works one bit at a time on a scan shift stream. A host clocks bits in on `tdi` and out on `tdo`, and `shift_en` marks every cycle in which one bit is exchanged. Toward the system bus it offers a plain word request/acknowledge interface that carries a word index. Address generation and the bus protocol itself belong to the neighbouring logic.

For a write burst, the engine ignores the stream until the host sends a single 1 start bit. It then receives the payload words and a 32-bit checksum, and answers with one verdict bit. Only when the checksum matches does it forward the words to the bus.

For a read burst, it first fetches every word from the bus. While that fetch runs it drives 0s on the stream. It then sends a single 1 marker, followed by the data and its checksum, so the host can locate the start of valid data however long the bus took.

The checksum is a bit-serial CRC-32 in reflected form. It uses polynomial 0xEDB88320, starts from all ones, and has no final inversion. Each word travels least-significant bit first, so its bytes go in little-endian order.

Top module: `dbg_burst_serdes`

## Requirements
- R1: While reset is asserted, and after it is released with no command given, `tdo` and `bus_req` are 0.
- R2: After a write command, every stream bit is ignored until the first 1 arrives on `tdi`. The payload begins with the bit that follows that 1.
- R3: The checksum starts at 0xFFFFFFFF. For each payload bit d, the value is shifted right by one, and 0xEDB88320 is XORed in when d XOR the old bit 0 is 1. No final XOR is applied, and the 32 checksum bits travel bit 0 first.
- R4: After the 32 checksum bits of a write, the next shifted-out bit is 1 when the received checksum equals the computed one. The engine then requests bus writes (`bus_we`=1) for indices 0 to N-1 in order, and each one carries the received word.
- R5: When the write checksum does not match, the verdict bit is 0, no bus request is made, and the stored memory contents stay as they were.
- R6: After a read command, the engine drives `tdo`=0 until all N words have been fetched. It then sends exactly one 1, followed by N data words and the 32-bit checksum of that data.
- R7: Bus read requests (`bus_we`=0) cover indices 0 to N-1 in order. Each request, together with its index, is held until `bus_ack` is 1, and `bus_rdata` is captured in that cycle.
- R8: Each word, whether received or sent, travels bit 0 first. The first eight bits of a word are therefore its lowest-addressed byte, bits 7:0, which gives little-endian byte order.
- R9: A write or read command that arrives while a burst is in progress is ignored.
- R10: In a cycle with `shift_en` low, no stream bit is consumed. Outside bus activity and command pulses, `tdo` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Starts a write burst (one-cycle pulse) |
| cmd_rd | input | 1 | Starts a read burst (one-cycle pulse) |
| cmd_len | input | LEN_W | Burst length N in words, from 1 to DEPTH |
| shift_en | input | 1 | One stream bit is exchanged in this cycle |
| tdi | input | 1 | Serial bit from the host |
| tdo | output | 1 | Serial bit to the host |
| bus_req | output | 1 | Bus word request |
| bus_we | output | 1 | 1 for a write request, 0 for a read request |
| bus_idx | output | IDX_W | Word index within the burst |
| bus_wdata | output | DATA_W | Word to be written |
| bus_rdata | input | DATA_W | Word returned by the bus |
| bus_ack | input | 1 | The bus has completed the current request |

## Verification
The bench builds the engine with 32-bit words and DEPTH=8. At that depth the longest burst the buffer can hold is a short run, so the single-word case, the full-buffer case and a corrupted checksum all fit in one run. Writes are read back through bus read bursts. This shows at the ports both the forwarded words and the memory that a rejected write left untouched. Varying the number of leading zeros and the acknowledge latency moves the start bit and the status marker to different positions in the stream.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WR_START, ST_WR_DATA, ST_WR_CRC, ST_WR_RESP, ST_WR_DRAIN,
    ST_RD_FETCH, ST_RD_STAT, ST_RD_DATA, ST_RD_CRC
  } bst_state_e;

  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  // reflected serial update: shift right, fold polynomial on (d ^ lsb)
  function automatic logic [31:0] crc_step(logic [31:0] c, logic d);
    return {1'b0, c[31:1]} ^ ((d ^ c[0]) ? CRC_POLY : 32'h0);
  endfunction
endpackage

// File: rtl/dbgb_crc_ser.sv
module dbgb_crc_ser
  import dbgb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (clr)     crc_d = CRC_SEED;
    else if (en) crc_d = crc_step(crc, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= CRC_SEED;
    else        crc <= crc_d;
  end
endmodule

// File: rtl/dbgb_word_buf.sv
module dbgb_word_buf #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic              bit_we,
  input  logic [BIT_W-1:0]  bit_sel,
  input  logic              bit_val,
  input  logic              word_we,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (word_we && idx == IDX_W'(i))
        mem[i] <= word_in;
      else if (bit_we && idx == IDX_W'(i))
        mem[i][bit_sel] <= bit_val;
    end
  end

  assign rd_word = mem[idx];
endmodule

// File: rtl/dbg_burst_serdes.sv
module dbg_burst_serdes
  import dbgb_pkg::*;
#(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              cmd_rd,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              shift_en,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_we,
  output logic [IDX_W-1:0]  bus_idx,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(CRC_W);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  bst_state_e       state_q, state_d;
  logic [IDX_W-1:0] widx_q, widx_d, last_q, last_d;
  logic [BIT_W-1:0] bidx_q, bidx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CRC_W-1:0] rx_q, rx_d, crc;
  logic             match_q, match_d;
  logic             crc_clr, crc_en, crc_din, bit_we, word_we;
  logic [DATA_W-1:0] rd_word;
  logic             word_end, burst_end, crc_end;

  assign word_end  = (bidx_q == BIT_W'(DATA_W - 1));
  assign burst_end = (widx_q == last_q);
  assign crc_end   = (cnt_q == CNT_W'(CRC_W - 1));

  dbgb_crc_ser i_crc (
    .clk(clk), .rst_n(rst_sn), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
  );

  dbgb_word_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_buf (
    .clk(clk), .idx(widx_q), .bit_we(bit_we), .bit_sel(bidx_q), .bit_val(tdi),
    .word_we(word_we), .word_in(bus_rdata), .rd_word(rd_word)
  );

  always_comb begin
    state_d = state_q;  widx_d = widx_q;  last_d = last_q;  bidx_d = bidx_q;
    cnt_d   = cnt_q;    rx_d   = rx_q;    match_d = match_q;
    crc_clr = 1'b0;     crc_en = 1'b0;    crc_din = tdi;
    bit_we  = 1'b0;     word_we = 1'b0;
    tdo = 1'b0;  bus_req = 1'b0;  bus_we = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        last_d = IDX_W'(cmd_len - LEN_W'(1));
        widx_d = '0;
        bidx_d = '0;
        if (cmd_wr) begin
          state_d = ST_WR_START;  crc_clr = 1'b1;
        end else if (cmd_rd) begin
          state_d = ST_RD_FETCH;  crc_clr = 1'b1;
        end
      end
      ST_WR_START: if (shift_en && tdi) state_d = ST_WR_DATA;
      ST_WR_DATA: if (shift_en) begin
        bit_we = 1'b1;
        crc_en = 1'b1;
        bidx_d = bidx_q + BIT_W'(1);
        if (word_end) begin
          bidx_d = '0;
          if (burst_end) begin
            state_d = ST_WR_CRC;  cnt_d = '0;
          end else widx_d = widx_q + IDX_W'(1);
        end
      end
      ST_WR_CRC: if (shift_en) begin
        rx_d  = {tdi, rx_q[CRC_W-1:1]};
        cnt_d = cnt_q + CNT_W'(1);
        if (crc_end) begin
          match_d = (rx_d == crc);
          state_d = ST_WR_RESP;
        end
      end
      ST_WR_RESP: begin
        tdo = match_q;
        if (shift_en) begin
          widx_d  = '0;
          state_d = match_q ? ST_WR_DRAIN : ST_IDLE;
        end
      end
      ST_WR_DRAIN: begin
        bus_req = 1'b1;
        bus_we  = 1'b1;
        if (bus_ack) begin
          if (burst_end) state_d = ST_IDLE;
          else           widx_d  = widx_q + IDX_W'(1);
        end
      end
      ST_RD_FETCH: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          word_we = 1'b1;
          if (burst_end) begin
            state_d = ST_RD_STAT;  widx_d = '0;
          end else widx_d = widx_q + IDX_W'(1);
        end
      end
      ST_RD_STAT: begin
        tdo = 1'b1;
        if (shift_en) state_d = ST_RD_DATA;
      end
      ST_RD_DATA: begin
        tdo     = rd_word[bidx_q];
        crc_din = rd_word[bidx_q];
        if (shift_en) begin
          crc_en = 1'b1;
          bidx_d = bidx_q + BIT_W'(1);
          if (word_end) begin
            bidx_d = '0;
            if (burst_end) begin
              state_d = ST_RD_CRC;  cnt_d = '0;
            end else widx_d = widx_q + IDX_W'(1);
          end
        end
      end
      ST_RD_CRC: begin
        tdo = crc[cnt_q];
        if (shift_en) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (crc_end) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign bus_idx   = widx_q;
  assign bus_wdata = rd_word;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;  widx_q <= '0;  last_q <= '0;  bidx_q <= '0;
      cnt_q   <= '0;       rx_q   <= '0;  match_q <= 1'b0;
    end else begin
      state_q <= state_d;  widx_q <= widx_d;  last_q <= last_d;  bidx_q <= bidx_d;
      cnt_q   <= cnt_d;    rx_q   <= rx_d;    match_q <= match_d;
    end
  end
endmodule

// File: rtl/dbgb_chk.sv
module dbgb_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic             cmd_wr,
  input logic             cmd_rd,
  input logic             tdo,
  input logic             bus_req,
  input logic             bus_we,
  input logic             bus_ack,
  input logic [IDX_W-1:0] bus_idx
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_idx) && $stable(bus_we));

  // R6
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> !tdo);

  // R4
  first_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> bus_idx == '0);

  // R10
  tdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en && !bus_req && !cmd_wr && !cmd_rd |=> $stable(tdo));
endmodule

bind dbg_burst_serdes dbgb_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
  .tdo(tdo), .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack), .bus_idx(bus_idx)
);

// File: tb/test_dbg_burst_serdes.sv
module test_dbg_burst_serdes;
  localparam int DW = 32, DEPTH = 8, IW = 3, LW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_rd = 0, shift_en = 0, tdi = 0, bus_ack = 0;
  logic [LW-1:0] cmd_len = '0;
  logic [DW-1:0] bus_rdata = '0;
  logic tdo, bus_req, bus_we;
  logic [IW-1:0] bus_idx;
  logic [DW-1:0] bus_wdata;

  always #5 clk = ~clk;

  dbg_burst_serdes #(.DATA_W(DW), .DEPTH(DEPTH)) i_dbg_burst_serdes (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_len(cmd_len),
    .shift_en(shift_en), .tdi(tdi), .tdo(tdo), .bus_req(bus_req), .bus_we(bus_we),
    .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  int checks = 0, fails = 0;
  logic [DW-1:0] exp_mem [DEPTH];
  logic [DW-1:0] bus_mem [DEPTH];
  logic [DW-1:0] burst_w [DEPTH];

  // vector: [27:12] seed, [11:8] leading zeros, [7:4] length, [0] corrupt checksum
  localparam logic [27:0] VEC [6] = '{
    {16'h1234, 4'd0, 4'd1, 3'b0, 1'b0},
    {16'h00A7, 4'd3, 4'd4, 3'b0, 1'b0},
    {16'hBEEF, 4'd7, 4'd8, 3'b0, 1'b0},
    {16'h0F0F, 4'd1, 4'd3, 3'b0, 1'b1},
    {16'h5555, 4'd2, 4'd2, 3'b0, 1'b0},
    {16'hC001, 4'd5, 4'd8, 3'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [DW-1:0] gen(int s, int k);
    return (32'(s) * 32'h9E37_79B1) ^ (32'(k) * 32'h85EB_CA6B) ^ 32'hA5A5_0000;
  endfunction

  // reference checksum from R3, over burst_w[0..n-1], bit 0 first
  function automatic logic [31:0] crc_of(int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < DW; b++)
        c = {1'b0, c[31:1]} ^ (((burst_w[k][b]) ^ c[0]) ? 32'hEDB8_8320 : 32'h0);
    return c;
  endfunction

  task automatic shift(input logic b, output logic o);
    @(negedge clk);
    tdi = b;  shift_en = 1'b1;  o = tdo;
  endtask

  task automatic pause();
    @(negedge clk);
    shift_en = 1'b0;  tdi = 1'b0;
  endtask

  task automatic wait_req(output bit seen);
    int t = 0;
    while (!bus_req && t < 60) begin @(negedge clk); t++; end
    seen = bus_req;
  endtask

  task automatic do_write(input int seed, input int lead, input int len,
                          input bit bad, input bit interfere);
    logic o;  logic [31:0] c;  bit seen;  int hits;
    string tag = bad ? "R5" : (interfere ? "R9" : "R4");
    for (int k = 0; k < len; k++) burst_w[k] = gen(seed, k);
    @(negedge clk);  cmd_wr = 1;  cmd_len = LW'(len);
    @(negedge clk);  cmd_wr = 0;
    for (int i = 0; i < lead; i++) shift(1'b0, o);     // R2 ignored zeros
    shift(1'b1, o);                                     // start bit
    for (int k = 0; k < len; k++) begin
      if (interfere && k == len / 2) begin             // R9 stray command
        @(negedge clk);  shift_en = 0;  cmd_rd = 1;  cmd_len = LW'(1);
        @(negedge clk);  cmd_rd = 0;
      end
      for (int b = 0; b < DW; b++) shift(burst_w[k][b], o);
    end
    c = crc_of(len);
    if (bad) c[5] = ~c[5];
    for (int b = 0; b < 32; b++) shift(c[b], o);
    shift(1'b0, o);
    chk(o == !bad, tag, "verdict bit", 64'(o), 64'(!bad));
    pause();
    if (!bad) begin
      for (int k = 0; k < len; k++) begin
        wait_req(seen);
        chk(seen && bus_we && bus_idx == IW'(k) && bus_wdata == burst_w[k], tag,
            "bus write {we,idx,data}", {bus_we, 27'(bus_idx), bus_wdata},
            {1'b1, 27'(k), burst_w[k]});
        if (k % 2 == 1) @(negedge clk);                 // extra wait before ack
        bus_mem[k] = bus_wdata;
        exp_mem[k] = burst_w[k];
        bus_ack = 1;
        @(negedge clk);  bus_ack = 0;
      end
      chk(!bus_req, tag, "no request after last write", 64'(bus_req), 64'd0);
    end else begin
      hits = 0;
      repeat (20) begin @(negedge clk); if (bus_req) hits++; end
      chk(hits == 0, "R5", "bus requests after mismatch", 64'(hits), 64'd0);
    end
  endtask

  task automatic do_read(input int len, input int lat, input bit interfere);
    logic o;  bit seen;  int pos;  logic [DW-1:0] got;  logic [31:0] rc, ec;
    @(negedge clk);  cmd_rd = 1;  cmd_len = LW'(len);
    @(negedge clk);  cmd_rd = 0;
    for (int i = 0; i < 3; i++) begin
      shift(1'b0, o);
      chk(o == 1'b0, "R6", "status zero during fetch", 64'(o), 64'd0);
    end
    pause();
    for (int k = 0; k < len; k++) begin
      wait_req(seen);
      chk(seen && !bus_we && bus_idx == IW'(k), "R7", "read request {we,idx}",
          {bus_we, 27'(bus_idx)}, {1'b0, 27'(k)});
      repeat (lat) @(negedge clk);
      chk(bus_req && bus_idx == IW'(k), "R7", "request held before ack",
          {bus_req, 27'(bus_idx)}, {1'b1, 27'(k)});
      bus_rdata = bus_mem[k];  bus_ack = 1;
      @(negedge clk);  bus_ack = 0;
    end
    pos = -1;
    for (int i = 0; i < 8 && pos < 0; i++) begin
      shift(1'b0, o);
      if (o) pos = i;
    end
    chk(pos == 0, "R6", "status marker position", 64'(pos), 64'd0);
    if (interfere) begin
      @(negedge clk);  shift_en = 0;  cmd_wr = 1;  cmd_len = LW'(2);
      @(negedge clk);  cmd_wr = 0;
    end
    for (int k = 0; k < len; k++) begin
      burst_w[k] = exp_mem[k];
      for (int b = 0; b < DW; b++) begin shift(1'b0, o); got[b] = o; end
      chk(got == exp_mem[k], interfere ? "R9" : "R6", "read word", 64'(got), 64'(exp_mem[k]));
      if (k == 0)
        chk(got[7:0] == exp_mem[0][7:0], "R8", "first byte out", 64'(got[7:0]),
            64'(exp_mem[0][7:0]));
    end
    ec = crc_of(len);
    for (int b = 0; b < 32; b++) begin shift(1'b0, o); rc[b] = o; end
    chk(rc == ec, "R3", "read checksum", 64'(rc), 64'(ec));
    shift(1'b0, o);
    chk(o == 1'b0, "R6", "idle after checksum", 64'(o), 64'd0);
    pause();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic o;
    for (int k = 0; k < DEPTH; k++) begin
      exp_mem[k] = 32'h1000_0000 + 32'(k);
      bus_mem[k] = exp_mem[k];
    end
    repeat (3) @(negedge clk);
    chk(tdo == 0 && bus_req == 0, "R1", "outputs in reset", {tdo, bus_req}, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(tdo == 0 && bus_req == 0, "R1", "outputs after reset", {tdo, bus_req}, 64'd0);

    // R10: stalled shift enable consumes nothing
    do_read(2, 0, 1'b0);

    // table walk: write a burst, then read it back
    for (int v = 0; v < 6; v++) begin
      do_write(int'(VEC[v][27:12]), int'(VEC[v][11:8]), int'(VEC[v][7:4]), VEC[v][0], 1'b0);
      do_read(int'(VEC[v][7:4]), int'(VEC[v][11:8]) % 3, 1'b0);
    end

    // R9: commands during an active burst
    do_write(16'h7E57, 2, 4, 1'b0, 1'b1);
    do_read(4, 1, 1'b1);

    // R1: reset in the middle of a write burst, then recovery
    @(negedge clk);  cmd_wr = 1;  cmd_len = LW'(2);
    @(negedge clk);  cmd_wr = 0;
    shift(1'b1, o);  shift(1'b1, o);  shift(1'b0, o);
    pause();
    rst_n = 0;
    @(negedge clk);
    chk(tdo == 0 && bus_req == 0, "R1", "outputs in mid-burst reset", {tdo, bus_req}, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(tdo == 0 && bus_req == 0, "R1", "outputs after mid-burst reset", {tdo, bus_req}, 64'd0);
    do_read(3, 2, 1'b0);

    finish_run();
  end
endmodule